// File: doc/BRIEF.md
# Uncached Address Classifier and Extender

This block sits after the untranslated (direct-mapped) path of an address unit. Each valid physical address is classified as cacheable or uncacheable, and the address is rewritten into a canonical 44-bit form. An address is uncacheable when either of two marker bits is set: bit 39 or bit 40. An uncacheable address gets its top nibble filled with ones. A cacheable address keeps its low 40 bits and has everything above them cleared.

Software is expected to use only one of the two marker conventions. The block keeps two sticky records of which convention it has seen, and it raises a sticky error when a later access uses the other one. A second sticky error reports an uncached access into the unimplemented internal-register window. An access on a speculative path never raises that error. Both errors and both convention records stay set until a synchronous clear or a reset. The classified address and flag come out one clock after the valid strobe.

Top module: `pa_uncached_classify`

## Requirements
- R1: `out_uc` is 1 exactly when bit 39 or bit 40 of the accepted address is set.
- R2: For an uncacheable access, `out_addr` bits 43:40 are all ones and bits 39:0 equal the input bits 39:0.
- R3: For a cacheable access, `out_addr` bits 43:40 are zero and bits 39:0 equal the input bits 39:0, whatever the input's upper bits held.
- R4: An accepted access with bit 40 set records the bit-40 convention. An access with only bit 39 set records the bit-39 convention. An address with both bits set counts as a bit-40 access only.
- R5: `err_mix` becomes 1 when a bit-40 access is accepted after the bit-39 record is set. It also becomes 1 when a bit-39-only access is accepted after the bit-40 record is set. Once set, it stays 1 until clear or reset.
- R6: `err_ireg` becomes 1 when an accepted uncacheable access has bits 39:32 equal to 8'hFF while `in_spec` is 0. While `in_spec` is 1, such an access does not set it. Once set, it stays 1 until clear or reset.
- R7: An access in the internal-register window still asserts `out_uc` and is extended as in R2, whether or not it is speculative.
- R8: When `clr` is high at a clock edge, both convention records and both errors are 0 after that edge. An access accepted in that same cycle still produces its output, but it records no convention and raises no error.
- R9: `out_vld`, `out_addr` and `out_uc` are registered: they update at the edge where `in_vld` is sampled high. `out_vld` is 0 in every other cycle. All outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of convention records and errors |
| in_vld | input | 1 | Address valid strobe |
| in_addr | input | 44 | Physical address from the direct-mapped path |
| in_spec | input | 1 | Access is on a speculative path |
| out_vld | output | 1 | Output address valid, one cycle after `in_vld` |
| out_addr | output | 44 | Canonical extended address |
| out_uc | output | 1 | Access is uncacheable |
| err_mix | output | 1 | Sticky: both marker conventions were used |
| err_ireg | output | 1 | Sticky: non-speculative access to the internal-register window |

## Verification
The bench gives an address with both marker bits set to a block that has already recorded the bit-40 convention. A design that treated this address as a bit-39 access would report a false conflict. It also sends a cached address with junk above bit 39 to catch a design that passes the upper bits through. The internal-register window is tested with and without the speculative flag, and an uncached address outside the window is tested too. A wrong decode would either miss the error or raise it for ordinary uncached accesses. Finally, clear is asserted in the same cycle as a conflicting access. A design that lets the access win would leave a stale convention record, and a later access of the other convention would then raise a spurious error.

// File: rtl/pa_uc_pkg.sv
package pa_uc_pkg;
   // classification of one accepted address
   typedef struct packed {
      logic uc;       // uncacheable
      logic conv_hi;  // counts as a bit-40 convention access
      logic conv_lo;  // counts as a bit-39-only convention access
      logic ireg;     // hits the internal-register window
   } pa_uc_class_t;
endpackage

// File: rtl/pa_uc_decode.sv
module pa_uc_decode #(
   parameter int ADDR_W   = 44,
   parameter int HI_BIT   = 40,
   parameter int LO_BIT   = 39,
   parameter int KEEP_W   = 40,
   parameter int IREG_EN  = 1,
   parameter int IREG_LSB = 32,
   parameter int IREG_W   = 8,
   parameter logic [IREG_W-1:0] IREG_VAL = '1
) (
   input  logic [ADDR_W-1:0]      addr,
   output logic [ADDR_W-1:0]      ext_addr,
   output pa_uc_pkg::pa_uc_class_t cls
);
   localparam int IREG_MSB = IREG_LSB + IREG_W - 1;

   logic uc;
   logic win_hit;

   assign uc = addr[HI_BIT] | addr[LO_BIT];

   // kept bits pass through, upper bits take the uncached marker
   for (genvar i = 0; i < ADDR_W; i++) begin : g_ext
      if (i < KEEP_W) begin : g_keep
         assign ext_addr[i] = addr[i];
      end else begin : g_fill
         assign ext_addr[i] = uc;
      end
   end

   if (IREG_EN != 0) begin : g_win
      assign win_hit = (addr[IREG_MSB:IREG_LSB] == IREG_VAL);
   end else begin : g_nowin
      assign win_hit = 1'b0;
   end

   always_comb begin
      cls.uc      = uc;
      cls.conv_hi = addr[HI_BIT];
      cls.conv_lo = addr[LO_BIT] & ~addr[HI_BIT];
      cls.ireg    = uc & win_hit;
   end
endmodule

// File: rtl/pa_uc_track.sv
module pa_uc_track (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    vld,
   input  logic                    spec,
   input  pa_uc_pkg::pa_uc_class_t cls,
   output logic                    err_mix,
   output logic                    err_ireg
);
   logic seen_hi, seen_lo;
   logic take;
   logic mix_now, ireg_now;

   assign take     = vld & ~clr;
   assign mix_now  = take & ((cls.conv_hi & seen_lo) | (cls.conv_lo & seen_hi));
   assign ireg_now = take & cls.ireg & ~spec;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         seen_hi  <= 1'b0;
         seen_lo  <= 1'b0;
         err_mix  <= 1'b0;
         err_ireg <= 1'b0;
      end else begin
         if (take && cls.conv_hi) seen_hi <= 1'b1;
         if (take && cls.conv_lo) seen_lo <= 1'b1;
         if (mix_now)  err_mix  <= 1'b1;
         if (ireg_now) err_ireg <= 1'b1;
      end
   end
endmodule

// File: rtl/pa_uncached_classify.sv
module pa_uncached_classify #(
   parameter int ADDR_W   = 44,
   parameter int HI_BIT   = 40,
   parameter int LO_BIT   = 39,
   parameter int KEEP_W   = 40,
   parameter int IREG_EN  = 1,
   parameter int IREG_LSB = 32,
   parameter int IREG_W   = 8,
   parameter logic [IREG_W-1:0] IREG_VAL = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              in_vld,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic              in_spec,
   output logic              out_vld,
   output logic [ADDR_W-1:0] out_addr,
   output logic              out_uc,
   output logic              err_mix,
   output logic              err_ireg
);
   // elaboration-time parameter checks
   if (HI_BIT >= ADDR_W || LO_BIT >= ADDR_W) begin : g_bad_bit
      $error("marker bit outside the address");
   end
   if (HI_BIT == LO_BIT) begin : g_same_bit
      $error("marker bits must differ");
   end
   if (KEEP_W > ADDR_W || LO_BIT >= KEEP_W) begin : g_bad_keep
      $error("kept width inconsistent with marker bits");
   end
   if (IREG_EN != 0 && IREG_LSB + IREG_W > KEEP_W) begin : g_bad_win
      $error("register window outside the kept field");
   end

   pa_uc_pkg::pa_uc_class_t cls;
   logic [ADDR_W-1:0]       ext_addr;

   pa_uc_decode #(
      .ADDR_W(ADDR_W), .HI_BIT(HI_BIT), .LO_BIT(LO_BIT), .KEEP_W(KEEP_W),
      .IREG_EN(IREG_EN), .IREG_LSB(IREG_LSB), .IREG_W(IREG_W),
      .IREG_VAL(IREG_VAL)
   ) u_dec (
      .addr     (in_addr),
      .ext_addr (ext_addr),
      .cls      (cls)
   );

   pa_uc_track u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .vld      (in_vld),
      .spec     (in_spec),
      .cls      (cls),
      .err_mix  (err_mix),
      .err_ireg (err_ireg)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_addr <= '0;
         out_uc   <= 1'b0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            out_addr <= ext_addr;
            out_uc   <= cls.uc;
         end
      end
   end
endmodule

// File: rtl/pa_uc_checker.sv
module pa_uc_checker #(
   parameter int ADDR_W   = 44,
   parameter int HI_BIT   = 40,
   parameter int LO_BIT   = 39,
   parameter int KEEP_W   = 40,
   parameter int IREG_EN  = 1,
   parameter int IREG_LSB = 32,
   parameter int IREG_W   = 8,
   parameter logic [IREG_W-1:0] IREG_VAL = '1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr,
   input logic              in_vld,
   input logic [ADDR_W-1:0] in_addr,
   input logic              in_spec,
   input logic              out_vld,
   input logic [ADDR_W-1:0] out_addr,
   input logic              out_uc,
   input logic              err_mix,
   input logic              err_ireg
);
   localparam int IREG_MSB = IREG_LSB + IREG_W - 1;

   p_uc_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_uc == ($past(in_addr[HI_BIT]) | $past(in_addr[LO_BIT])));

   p_fill_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && out_uc) |-> &out_addr[ADDR_W-1:KEEP_W]);

   p_fill_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !out_uc) |-> out_addr[ADDR_W-1:KEEP_W] == '0);

   p_keep_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_addr[KEEP_W-1:0] == $past(in_addr[KEEP_W-1:0]));

   p_mix_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (err_mix && !clr) |=> err_mix);

   p_ireg_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (err_ireg && !clr) |=> err_ireg);

   p_ireg_spec_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_spec && !err_ireg) |=> !err_ireg);

   p_ireg_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (IREG_EN != 0 && in_vld && !in_spec && !clr
       && (in_addr[HI_BIT] || in_addr[LO_BIT])
       && in_addr[IREG_MSB:IREG_LSB] == IREG_VAL) |=> err_ireg);

   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!err_mix && !err_ireg));

   p_vld_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld == $past(in_vld) || $rose(rst_n));
endmodule

bind pa_uncached_classify pa_uc_checker #(
   .ADDR_W(ADDR_W), .HI_BIT(HI_BIT), .LO_BIT(LO_BIT), .KEEP_W(KEEP_W),
   .IREG_EN(IREG_EN), .IREG_LSB(IREG_LSB), .IREG_W(IREG_W),
   .IREG_VAL(IREG_VAL)
) u_chk (.*);

// File: tb/tb_pa_uncached_classify.sv
`timescale 1ns/1ps
module tb_pa_uncached_classify;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        in_vld = 1'b0;
   logic [43:0] in_addr = '0;
   logic        in_spec = 1'b0;
   logic        out_vld;
   logic [43:0] out_addr;
   logic        out_uc;
   logic        err_mix;
   logic        err_ireg;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pa_uncached_classify dut (.*);

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one access: driven at a falling edge, result visible at the next one
   task automatic send(input logic [43:0] a, input logic sp, input logic c);
      @(negedge clk);
      in_vld = 1'b1; in_addr = a; in_spec = sp; clr = c;
      @(negedge clk);
      in_vld = 1'b0; in_spec = 1'b0; clr = 1'b0;
   endtask

   task automatic do_clear();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
   endtask

   task automatic t_reset();
      chk(out_vld == 0 && out_uc == 0 && out_addr == 0, "R9 reset outputs",
          {out_vld, out_uc, out_addr}, 0);
      chk(err_mix == 0 && err_ireg == 0, "R9 reset errors", {err_mix, err_ireg}, 0);
   endtask

   task automatic t_cached();
      send(44'hA_0A_1234_5678, 1'b0, 1'b0);
      chk(out_vld == 1, "R9 valid follows strobe", out_vld, 1);
      chk(out_uc == 0, "R1 cached flag", out_uc, 0);
      chk(out_addr == 44'h0_0A_1234_5678, "R3 cached extension", out_addr, 44'h0_0A_1234_5678);
      @(negedge clk);
      chk(out_vld == 0, "R9 valid drops when idle", out_vld, 0);
   endtask

   task automatic t_uncached39();
      send(44'h0_80_0000_1000, 1'b0, 1'b0);
      chk(out_uc == 1, "R1 bit39 uncached", out_uc, 1);
      chk(out_addr == 44'hF_80_0000_1000, "R2 bit39 extension", out_addr, 44'hF_80_0000_1000);
      chk(err_mix == 0, "R4 first convention no error", err_mix, 0);
      do_clear();
   endtask

   task automatic t_priority();
      send(44'h1_00_0000_2000, 1'b0, 1'b0);  // bit 40 only
      chk(out_uc == 1 && out_addr == 44'hF_00_0000_2000, "R2 bit40 extension",
          out_addr, 44'hF_00_0000_2000);
      send(44'h1_80_0000_3000, 1'b0, 1'b0);  // both bits: still bit-40
      chk(err_mix == 0, "R4 both bits counts as bit40", err_mix, 0);
      send(44'h0_80_0000_4000, 1'b0, 1'b0);  // bit-39 only after bit-40
      chk(err_mix == 1, "R5 bit39 after bit40 conflict", err_mix, 1);
      send(44'h0_00_0000_5000, 1'b0, 1'b0);
      chk(err_mix == 1, "R5 error holds", err_mix, 1);
      do_clear();
      chk(err_mix == 0, "R8 clear drops mix error", err_mix, 0);
   endtask

   task automatic t_reverse();
      send(44'h0_80_0000_0040, 1'b0, 1'b0);
      send(44'h1_00_0000_0080, 1'b0, 1'b0);
      chk(err_mix == 1, "R5 bit40 after bit39 conflict", err_mix, 1);
      do_clear();
   endtask

   task automatic t_ireg();
      send(44'h0_80_0000_0000, 1'b0, 1'b0);
      chk(err_ireg == 0, "R6 uncached outside window", err_ireg, 0);
      send(44'h0_FF_0000_0010, 1'b1, 1'b0);
      chk(err_ireg == 0, "R6 speculative suppressed", err_ireg, 0);
      chk(out_uc == 1 && out_addr == 44'hF_FF_0000_0010, "R7 speculative window uncached",
          out_addr, 44'hF_FF_0000_0010);
      send(44'h0_FF_0000_0020, 1'b0, 1'b0);
      chk(err_ireg == 1, "R6 window error", err_ireg, 1);
      chk(out_uc == 1, "R7 window still uncached", out_uc, 1);
      send(44'h0_00_0000_0000, 1'b0, 1'b0);
      chk(err_ireg == 1, "R6 window error holds", err_ireg, 1);
      do_clear();
      chk(err_ireg == 0, "R8 clear drops window error", err_ireg, 0);
   endtask

   task automatic t_clr_collide();
      send(44'h1_00_0000_0000, 1'b0, 1'b0);  // record bit-40
      send(44'h0_80_0000_0100, 1'b0, 1'b0);  // conflict
      chk(err_mix == 1, "R5 conflict before collide", err_mix, 1);
      send(44'h0_FF_0000_0200, 1'b0, 1'b1);  // conflicting window access with clear
      chk(err_mix == 0 && err_ireg == 0, "R8 clear wins over access",
          {err_mix, err_ireg}, 0);
      chk(out_vld == 1 && out_addr == 44'hF_FF_0000_0200, "R8 access output during clear",
          out_addr, 44'hF_FF_0000_0200);
      send(44'h1_00_0000_0300, 1'b0, 1'b0);  // bit-39 must not have been recorded
      chk(err_mix == 0, "R8 no record from cleared cycle", err_mix, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cached();
      t_uncached39();
      t_priority();
      t_reverse();
      t_ireg();
      t_clr_collide();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule